// File: doc/BRIEF.md
# Flash Write Status Bit Generator

This block builds the status byte that a host reads from a NOR flash controller while an internal program or erase operation runs or is held in erase-suspend. The operation sequencer tells it what is going on: a program is busy, an erase is busy, the erase is suspended, the erase has left its acceptance window, which sectors are marked for erase, bit 7 of the datum being programmed, and a pulse-limit failure. The host side supplies a read strobe and a read address. From these the block forms a polling bit, a device-wide toggle bit, a per-sector toggle bit, a limit-exceeded flag, an erase-window flag and an active-low ready/busy line.

Together the polling bit and the two toggle bits let a host tell an active erase, an erase-suspend and a finished operation apart. A program or erase aimed at protected sectors does no work but still shows busy status for a short window. That window is a down-counter in clock cycles, set by a parameter. The sequencer starts it with a single pulse.

Top module: `flash_status_gen`

## Requirements
- R1: After reset with all inputs low, status reads 8'h00 and ry_by_n is 1.
- R2: While a program is active (prog_busy, or the protected-program window), status[7] is the inverse of prog_d7. With no operation active and no suspend, status[7] equals prog_d7.
- R3: While an erase is active (erase_busy and not erase_susp, or the protected-erase window) and no program is active, status[7] is 0. While the erase is suspended and no program runs, status[7] is 1.
- R4: status[6] inverts once per host read (rising edge of rd_stb, whatever its width) while a program or an unsuspended erase is active, including a program inside erase-suspend. It holds its value when idle or suspended with no program.
- R5: status[2] inverts once per host read whose sector (the top log2(NSECT) bits of rd_addr) has its bit set in sel_mask, while an erase is active or suspended. Reads of unselected sectors, and all reads when no erase is active or suspended, leave it unchanged.
- R6: status[5] is set by a pulse_fail cycle and then stays 1 until a reset_cmd cycle clears it. If both come in the same cycle, set wins.
- R7: status[3] is 0 during an erase until erase_started is seen. From the next cycle it is 1, and it returns to 0 when erase_busy drops.
- R8: A prot_prog_start pulse makes the block show an active program (ry_by_n 0, polling and toggling as in R2 and R4) for exactly PROT_PROG_CYC cycles.
- R9: A prot_erase_start pulse makes the block show an active erase (ry_by_n 0, as in R3 to R5) for exactly PROT_ERASE_CYC cycles.
- R10: ry_by_n is 0 while any program or unsuspended erase is active. It is 1 when idle or when suspended with no program running.
- R11: status bits 4, 1 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_busy | input | 1 | Program operation running |
| erase_busy | input | 1 | Erase operation in place (running or suspended) |
| erase_susp | input | 1 | Erase held in suspend |
| erase_started | input | 1 | Erase acceptance window has closed |
| sel_mask | input | NSECT | Sectors marked for erase |
| prog_d7 | input | 1 | Bit 7 of the datum being programmed |
| pulse_fail | input | 1 | Pulse-count limit exceeded |
| reset_cmd | input | 1 | Reset command written |
| prot_prog_start | input | 1 | Program aimed at a protected sector |
| prot_erase_start | input | 1 | Erase with all selected sectors protected |
| rd_stb | input | 1 | Host read strobe |
| rd_addr | input | ADDR_W | Host read address |
| status | output | 8 | Status byte |
| ry_by_n | output | 1 | Ready (1) / busy (0) |

## Verification
A toggle flip-flop that advances on the wrong condition shows up at the very next host read: status[6] or status[2] fails to invert, or inverts when it should hold. That is why the bench compares every read of every address under every sector mask. A bad protected-window count moves the rising edge of ry_by_n by at least one cycle, and the bench checks the exact cycle. A lost sticky limit flag or a wrong erase-window flag is visible on the next cycle's status byte.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  localparam int POLL_BIT   = 7;
  localparam int TOG_DEV    = 6;
  localparam int LIMIT_BIT  = 5;
  localparam int EWIN_BIT   = 3;
  localparam int TOG_SECT   = 2;

  typedef struct packed {
    logic prog;
    logic erase;
    logic susp;
  } fsg_mode_t;
endpackage

// File: rtl/fsg_window.sv
module fsg_window #(
  parameter int LEN = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LOADV = CW'(LEN);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (start)    cnt <= LOADV;
    else if (cnt != 0) cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);

  // R8 / R9: window counts down one per cycle once started
  assert_window_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start) |=> (cnt == $past(cnt) - 1'b1));
  assert_window_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> active);
endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (adv) q <= ~q;
  end

  assert_toggle_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (q != $past(q)));
  assert_toggle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(q));
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import fsg_pkg::*;
#(
  parameter int ADDR_W         = 8,
  parameter int NSECT          = 4,
  parameter int PROT_PROG_CYC  = 200,
  parameter int PROT_ERASE_CYC = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_busy,
  input  logic              erase_busy,
  input  logic              erase_susp,
  input  logic              erase_started,
  input  logic [NSECT-1:0]  sel_mask,
  input  logic              prog_d7,
  input  logic              pulse_fail,
  input  logic              reset_cmd,
  input  logic              prot_prog_start,
  input  logic              prot_erase_start,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        status,
  output logic              ry_by_n
);
  localparam int SW = (NSECT > 1) ? $clog2(NSECT) : 1;

  function automatic logic [SW-1:0] sect_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: SW];
  endfunction

  function automatic logic sect_selected(input logic [ADDR_W-1:0] a,
                                         input logic [NSECT-1:0] m);
    return m[sect_of(a)];
  endfunction

  // named internal events
  logic      pp_win, pe_win;
  logic      rd_q, rd_rise;
  logic      t6, t2;
  logic      lim_q, ewin_q;
  logic      hit_sel;
  fsg_mode_t mode;
  logic      any_busy, erase_visible, adv6, adv2;

  fsg_window #(.LEN(PROT_PROG_CYC)) u_pp_win (
    .clk(clk), .rst_n(rst_n), .start(prot_prog_start), .active(pp_win));
  fsg_window #(.LEN(PROT_ERASE_CYC)) u_pe_win (
    .clk(clk), .rst_n(rst_n), .start(prot_erase_start), .active(pe_win));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd_stb;
  end
  assign rd_rise = rd_stb & ~rd_q;

  always_comb begin
    mode.prog  = prog_busy | pp_win;
    mode.erase = (erase_busy & ~erase_susp) | pe_win;
    mode.susp  = erase_busy & erase_susp & ~pe_win;
  end

  assign any_busy      = mode.prog | mode.erase;
  assign erase_visible = mode.erase | mode.susp;
  assign hit_sel       = sect_selected(rd_addr, sel_mask);
  assign adv6          = rd_rise & any_busy;
  assign adv2          = rd_rise & erase_visible & hit_sel;

  fsg_toggle u_tog_dev  (.clk(clk), .rst_n(rst_n), .adv(adv6), .q(t6));
  fsg_toggle u_tog_sect (.clk(clk), .rst_n(rst_n), .adv(adv2), .q(t2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lim_q <= 1'b0;
    else if (pulse_fail) lim_q <= 1'b1;
    else if (reset_cmd)  lim_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             ewin_q <= 1'b0;
    else if (!erase_busy)   ewin_q <= 1'b0;
    else if (erase_started) ewin_q <= 1'b1;
  end

  logic poll;
  always_comb begin
    if (mode.prog)       poll = ~prog_d7;
    else if (mode.erase) poll = 1'b0;
    else if (mode.susp)  poll = 1'b1;
    else                 poll = prog_d7;
  end

  always_comb begin
    status            = 8'h00;
    status[POLL_BIT]  = poll;
    status[TOG_DEV]   = t6;
    status[LIMIT_BIT] = lim_q;
    status[EWIN_BIT]  = ewin_q;
    status[TOG_SECT]  = t2;
  end

  assign ry_by_n = ~any_busy;

  // R4: a read while idle leaves the device toggle bit alone at the port
  assert_idle_no_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && ry_by_n) |=> $stable(status[TOG_DEV]));
  // R5: unselected-sector read never moves the sector toggle bit
  assert_unsel_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && !hit_sel) |=> $stable(status[TOG_SECT]));
  // R6: limit flag is sticky without a reset command
  assert_limit_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[LIMIT_BIT] && !reset_cmd) |=> status[LIMIT_BIT]);
  // R7: erase-window flag only rises after erase_started
  assert_ewin_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[EWIN_BIT]) |-> $past(erase_started && erase_busy));
  // R8: a protected program start shows busy next cycle
  assert_prot_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prot_prog_start |=> !ry_by_n);
  // R11: unused bits stay clear
  assert_unused_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4] == 1'b0) && (status[1:0] == 2'b00));
endmodule

// File: tb/tb_flash_status_gen.sv
module tb_flash_status_gen;
  localparam int CLK_PER = 10;
  localparam int AW  = 6;
  localparam int NS  = 4;
  localparam int PPC = 5;
  localparam int PEC = 12;

  logic clk = 0, rst_n = 0;
  logic prog_busy = 0, erase_busy = 0, erase_susp = 0, erase_started = 0;
  logic [NS-1:0] sel_mask = '0;
  logic prog_d7 = 0, pulse_fail = 0, reset_cmd = 0;
  logic prot_prog_start = 0, prot_erase_start = 0;
  logic rd_stb = 0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] status;
  logic ry_by_n;

  int errs = 0, checks = 0;
  logic e6 = 0, e2 = 0;

  always #(CLK_PER/2) clk = ~clk;

  flash_status_gen #(.ADDR_W(AW), .NSECT(NS), .PROT_PROG_CYC(PPC),
                     .PROT_ERASE_CYC(PEC)) dut (.*);

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  // read with strobe width w; bench model decides which toggles advance
  task automatic rd(input logic [AW-1:0] a, input int w, input logic act6, input logic act2);
    rd_addr = a;
    chk(status[6] == e6, "R4 bit6 pre-read", status[6], e6);
    chk(status[2] == e2, "R5 bit2 pre-read", status[2], e2);
    rd_stb = 1;
    for (int i = 0; i < w; i++) tick();
    rd_stb = 0;
    tick();
    if (act6) e6 = ~e6;
    if (act2 && sel_mask[a[AW-1 -: 2]]) e2 = ~e2;
    chk(status[6] == e6, "R4 bit6 post-read", status[6], e6);
    chk(status[2] == e2, "R5 bit2 post-read", status[2], e2);
  endtask

  initial begin
    #(CLK_PER * 200000);
    errs++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    tick();
    // R1 reset state
    chk(status == 8'h00, "R1 status", status, 0);
    chk(ry_by_n == 1'b1, "R1 ry_by_n", ry_by_n, 1);
    // R11 always zero
    chk((status & 8'h13) == 0, "R11 unused", status & 8'h13, 0);

    // R2 polling during program and after
    for (int d = 0; d < 2; d++) begin
      prog_d7 = d[0];
      prog_busy = 1; tick();
      chk(status[7] == ~d[0], "R2 program poll", status[7], ~d[0]);
      chk(ry_by_n == 0, "R10 busy in program", ry_by_n, 0);
      for (int k = 0; k < 3; k++) rd(6'(k * 17), 1 + k, 1'b1, 1'b0);
      prog_busy = 0; tick();
      chk(status[7] == d[0], "R2 done poll", status[7], d[0]);
      chk(ry_by_n == 1, "R10 ready idle", ry_by_n, 1);
      rd(6'h05, 1, 1'b0, 1'b0);   // R4 idle read holds
    end

    // R3/R4/R5/R7 erase sweep over all masks and addresses
    prog_d7 = 1;
    erase_busy = 1; tick();
    chk(status[3] == 0, "R7 window open", status[3], 0);
    erase_started = 1; tick(); erase_started = 0;
    chk(status[3] == 1, "R7 window closed", status[3], 1);
    for (int s = 0; s < 2; s++) begin
      erase_susp = s[0];
      for (int m = 0; m < 16; m++) begin
        sel_mask = 4'(m);
        tick();
        chk(status[7] == s[0], "R3 erase poll", status[7], s[0]);
        chk(ry_by_n == s[0], "R10 erase ready", ry_by_n, s[0]);
        for (int a = 0; a < 64; a++) rd(6'(a), 1, ~s[0], 1'b1);
      end
    end
    // program inside suspend (erase_susp still 1)
    prog_busy = 1; prog_d7 = 0; tick();
    chk(status[7] == 1, "R2 suspend program poll", status[7], 1);
    chk(ry_by_n == 0, "R10 suspend program busy", ry_by_n, 0);
    rd(6'h00, 2, 1'b1, 1'b1);
    rd(6'h30, 1, 1'b1, 1'b1);
    prog_busy = 0; tick();
    rd(6'h10, 1, 1'b0, 1'b1);
    erase_susp = 0; erase_busy = 0; tick();
    chk(status[3] == 0, "R7 cleared", status[3], 0);
    rd(6'h3F, 1, 1'b0, 1'b0);   // no erase: R5 no toggle

    // R6 sticky limit flag
    pulse_fail = 1; tick(); pulse_fail = 0;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk(status[5] == 1, "R6 sticky", status[5], 1);
    end
    pulse_fail = 1; reset_cmd = 1; tick();
    chk(status[5] == 1, "R6 set wins", status[5], 1);
    pulse_fail = 0; tick(); reset_cmd = 0;
    chk(status[5] == 0, "R6 cleared", status[5], 0);

    // R8 protected program window length
    prog_d7 = 1;
    prot_prog_start = 1; tick(); prot_prog_start = 0;
    for (int k = 0; k < PPC; k++) begin
      chk(ry_by_n == 0, "R8 window busy", ry_by_n, 0);
      chk(status[7] == 0, "R8 poll inverted", status[7], 0);
      if (k == 0) begin
        rd(6'h01, 1, 1'b1, 1'b0);
        k++;
      end else tick();
    end
    chk(ry_by_n == 1, "R8 window end", ry_by_n, 1);

    // R9 protected erase window length
    sel_mask = 4'b0100;
    prot_erase_start = 1; tick(); prot_erase_start = 0;
    for (int k = 0; k < PEC; k++) begin
      chk(ry_by_n == 0, "R9 window busy", ry_by_n, 0);
      chk(status[7] == 0, "R9 poll zero", status[7], 0);
      if (k == 0) begin
        rd(6'h20, 1, 1'b1, 1'b1);
        k++;
      end else tick();
    end
    chk(ry_by_n == 1, "R9 window end", ry_by_n, 1);
    chk((status & 8'h13) == 0, "R11 unused end", status & 8'h13, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule